// File: doc/BRIEF.md
# HDLC Frame Receiver with Address Filter

This block is the receive half of a bit-oriented HDLC link. It takes a serial line one bit at a time, qualified by a bit-enable strobe. It searches the stream for the flag pattern to gain frame sync, strips the zeros the sender stuffed after runs of five ones, and runs the CRC-16 frame check over the frame. It can also filter frames on their first (address) byte. Flags never reach the output. The two FCS bytes at the end of a frame are held back and not delivered.

Accepted bytes leave on a one-cycle byte interface with first and last markers. The last beat of a frame carries a good/bad FCS verdict. Single-cycle pulses report line idle, Go-Ahead, frame abort and end of packet.

A transparent mode turns framing off. In that mode the block simply packs every eight raw bits into a byte.

Top module: `hdlc_rx`

## Requirements
- R1: After a flag (01111110) the receiver is in sync. Data bits are packed least significant bit first. Flags never appear on the output. The first delivered byte of a frame has `out_first` high, and the final delivered byte has `out_last` high.
- R2: A 0 that directly follows five consecutive 1s inside a frame is removed before byte packing and CRC.
- R3: The last two bytes before the closing flag are the FCS and are not delivered. On the last beat, `out_fcs_ok` is 1 only if all of the following hold: the CRC register (initial value FFFF, reflected polynomial 8408 hex, run over data plus FCS) ends at F0B8 hex, the frame is a whole number of bytes, and the frame has at least 32 bits.
- R4: A frame with fewer than 24 bits between flags produces no output beat and no end-of-packet pulse.
- R5: A frame of 24 to 31 bits has its data bytes delivered, with the last beat marked bad FCS.
- R6: A frame whose bit count is not a multiple of eight is marked bad FCS.
- R7: With `addr_filter_en` high, a frame is delivered only in two cases: its first byte equals `station_addr` on bits 7..1 (bits 7..2 when `addr_six_bit` is high), or its first byte is FF hex. With `addr_filter_en` low, every frame is delivered. A rejected frame still gives its end-of-packet pulse.
- R8: A seventh consecutive 1 aborts the frame, and the receiver hunts for a new flag. For an aborted frame of at least 24 bits, `eop_pulse` fires and the oldest held byte is delivered as the last beat with bad FCS. `abort_pulse` fires only if the aborted frame had at least 32 bits.
- R9: `eop_pulse` fires on the closing flag of every frame of 24 or more bits.
- R10: `idle_pulse` fires once, on the fifteenth consecutive 1.
- R11: `ga_pulse` fires when a 0 follows exactly seven 1s that were preceded by a 0. A run of eight or more 1s followed by a 0 does not fire it.
- R12: With `transparent` high, every eight strobed bits form one byte, packed least significant bit first. That byte is delivered with first, last and FCS-ok all low. No status or end-of-packet pulses are produced in this mode.
- R13: After reset every output is low. Outputs change only in the cycle after a strobed bit, and each pulse lasts one clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Strobe: `bit_in` is valid this cycle |
| bit_in | input | 1 | Serial line bit |
| transparent | input | 1 | Raw byte packing, no framing |
| addr_filter_en | input | 1 | Enable first-byte address filter |
| addr_six_bit | input | 1 | Compare only bits 7..2 of the address |
| station_addr | input | 8 | Own station address |
| out_valid | output | 1 | Byte beat valid |
| out_data | output | 8 | Delivered byte |
| out_first | output | 1 | Beat is the first byte of a frame |
| out_last | output | 1 | Beat is the last byte of a frame |
| out_fcs_ok | output | 1 | Frame check good (last beat only) |
| eop_pulse | output | 1 | End of packet |
| abort_pulse | output | 1 | Abort after at least 32 bits |
| idle_pulse | output | 1 | Fifteenth consecutive 1 seen |
| ga_pulse | output | 1 | Go-Ahead pattern seen |

## Verification
Every result is registered once. A beat or pulse caused by a strobed bit is therefore visible in the clock cycle right after that bit's strobe edge, and only for that cycle.

The bench drives each bit on a falling edge, holds the strobe for one cycle, and samples the outputs on the following falling edge, which lands exactly in that cycle. A monitor on falling edges records every beat and counts every pulse. A pulse that lasted two cycles would be counted twice.

Data bytes are delivered when a later byte completes, or at the closing flag or the abort. For this reason, each scenario closes its frame, waits a few idle cycles, and only then compares the recorded beats and pulse counts with values computed from the frames it sent.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;
    localparam int BYTE_W = 8;
    localparam int PART_W = BYTE_W - 1;
    localparam int FLAG_LEN = 8;
    localparam int SPAN_W = $clog2(FLAG_LEN);
    localparam logic [15:0] CRC_INIT = 16'hFFFF;
    localparam logic [15:0] CRC_POLY = 16'h8408;
    localparam logic [15:0] CRC_GOOD = 16'hF0B8;

    typedef enum logic {
        ST_HUNT  = 1'b0,
        ST_FRAME = 1'b1
    } rx_state_e;
endpackage

// File: rtl/hdlc_rx_linemon.sv
module hdlc_rx_linemon #(
    parameter int IDLE_RUN = 15
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic bit_in,
    output logic ev_flag,
    output logic ev_stuff,
    output logic ev_abort,
    output logic ev_idle,
    output logic ev_ga,
    output logic ev_data
);
    localparam int RUN_W = $clog2(IDLE_RUN + 1);
    localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(IDLE_RUN);

    logic [RUN_W-1:0] ones_d, ones_q;

    always_comb begin
        ones_d = ones_q;
        if (bit_en) begin
            if (!bit_in) begin
                ones_d = '0;
            end else if (ones_q != RUN_MAX) begin
                ones_d = ones_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ones_q <= '0;
        end else begin
            ones_q <= ones_d;
        end
    end

    always_comb begin
        ev_flag  = bit_en && !bit_in && (ones_q == RUN_W'(6));
        ev_stuff = bit_en && !bit_in && (ones_q == RUN_W'(5));
        ev_ga    = bit_en && !bit_in && (ones_q == RUN_W'(7));
        ev_abort = bit_en && bit_in && (ones_q == RUN_W'(6));
        ev_idle  = bit_en && bit_in && (ones_q == RUN_W'(IDLE_RUN - 1));
        ev_data  = bit_en && !ev_flag && !ev_stuff && !(bit_in && ones_q >= RUN_W'(6))
                   && !(!bit_in && ones_q >= RUN_W'(7));
    end
endmodule

// File: rtl/hdlc_rx_crc_step.sv
module hdlc_rx_crc_step
    import hdlc_rx_pkg::*;
(
    input  logic [15:0] crc_in,
    input  logic        bit_in,
    output logic [15:0] crc_out
);
    logic fb;

    always_comb begin
        fb      = crc_in[0] ^ bit_in;
        crc_out = {1'b0, crc_in[15:1]} ^ (fb ? CRC_POLY : 16'h0000);
    end
endmodule

// File: rtl/hdlc_rx_addr_match.sv
module hdlc_rx_addr_match #(
    parameter int W = 8
) (
    input  logic [W-1:0] addr_byte,
    input  logic [W-1:0] station,
    input  logic         six_bit,
    output logic         hit
);
    localparam logic [W-1:0] MASK7 = {{(W-1){1'b1}}, 1'b0};
    localparam logic [W-1:0] MASK6 = {{(W-2){1'b1}}, 2'b00};

    logic [W-1:0] mask;

    always_comb begin
        mask = six_bit ? MASK6 : MASK7;
        hit  = (((addr_byte ^ station) & mask) == '0) || (addr_byte == '1);
    end
endmodule

// File: rtl/hdlc_rx.sv
module hdlc_rx
    import hdlc_rx_pkg::*;
#(
    parameter int LEN_W            = 16,
    parameter int MIN_DELIVER_BITS = 24,
    parameter int MIN_GOOD_BITS    = 32,
    parameter int IDLE_RUN         = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              bit_in,
    input  logic              transparent,
    input  logic              addr_filter_en,
    input  logic              addr_six_bit,
    input  logic [BYTE_W-1:0] station_addr,
    output logic              out_valid,
    output logic [BYTE_W-1:0] out_data,
    output logic              out_first,
    output logic              out_last,
    output logic              out_fcs_ok,
    output logic              eop_pulse,
    output logic              abort_pulse,
    output logic              idle_pulse,
    output logic              ga_pulse
);
    localparam int BCNT_W = $clog2(BYTE_W);
    localparam logic [BCNT_W-1:0] BCNT_LAST = BCNT_W'(BYTE_W - 1);
    localparam logic [SPAN_W-1:0] DLY_FULL = SPAN_W'(FLAG_LEN - 1);
    localparam logic [LEN_W-1:0] DELIVER_LEN = LEN_W'(MIN_DELIVER_BITS);
    localparam logic [LEN_W-1:0] GOOD_LEN = LEN_W'(MIN_GOOD_BITS);
    localparam logic [LEN_W-1:0] FIRST_BYTE_END = LEN_W'(BYTE_W - 1);

    typedef struct packed {
        rx_state_e          st;
        logic [FLAG_LEN-2:0] dly;
        logic [SPAN_W-1:0]  dcnt;
        logic [PART_W-1:0]  sr;
        logic [BCNT_W-1:0]  bcnt;
        logic [LEN_W-1:0]   nbits;
        logic [15:0]        crc;
        logic [BYTE_W-1:0]  h0;
        logic [BYTE_W-1:0]  h1;
        logic [BYTE_W-1:0]  h2;
        logic [1:0]         hcnt;
        logic               accept;
        logic               emitted;
        logic               trans;
        logic               ov;
        logic [BYTE_W-1:0]  od;
        logic               of;
        logic               ol;
        logic               ok;
        logic               eop;
        logic               ab;
        logic               idl;
        logic               ga;
    } rx_reg_t;

    rx_reg_t d, q;

    logic ev_flag, ev_stuff, ev_abort, ev_idle, ev_ga, ev_data;
    logic asm_bit;
    logic [BYTE_W-1:0] asm_byte;
    logic [15:0] crc_nxt;
    logic addr_hit;
    logic [BCNT_W-1:0] raw_cnt;

    hdlc_rx_linemon #(.IDLE_RUN(IDLE_RUN)) u_linemon (
        .clk     (clk),
        .rst_n   (rst_n),
        .bit_en  (bit_en),
        .bit_in  (bit_in),
        .ev_flag (ev_flag),
        .ev_stuff(ev_stuff),
        .ev_abort(ev_abort),
        .ev_idle (ev_idle),
        .ev_ga   (ev_ga),
        .ev_data (ev_data)
    );

    hdlc_rx_crc_step u_crc (
        .crc_in (q.crc),
        .bit_in (q.dly[FLAG_LEN-2]),
        .crc_out(crc_nxt)
    );

    hdlc_rx_addr_match #(.W(BYTE_W)) u_addr (
        .addr_byte(asm_byte),
        .station  (station_addr),
        .six_bit  (addr_six_bit),
        .hit      (addr_hit)
    );

    assign asm_bit  = transparent ? bit_in : q.dly[FLAG_LEN-2];
    assign asm_byte = {asm_bit, q.sr};
    assign raw_cnt  = q.trans ? q.bcnt : '0;

    always_comb begin
        d     = q;
        d.ov  = 1'b0;
        d.of  = 1'b0;
        d.ol  = 1'b0;
        d.ok  = 1'b0;
        d.eop = 1'b0;
        d.ab  = 1'b0;
        d.idl = 1'b0;
        d.ga  = 1'b0;
        if (bit_en) begin
            d.trans = transparent;
            if (transparent) begin
                // raw packing, framing held in hunt
                d.st   = ST_HUNT;
                d.dcnt = '0;
                if (raw_cnt == BCNT_LAST) begin
                    d.ov   = 1'b1;
                    d.od   = asm_byte;
                    d.bcnt = '0;
                end else begin
                    d.sr   = {bit_in, q.sr[PART_W-1:1]};
                    d.bcnt = raw_cnt + 1'b1;
                end
            end else begin
                if (q.trans) begin
                    d.bcnt = '0;
                end
                d.idl = ev_idle;
                d.ga  = ev_ga;
                if (ev_flag) begin
                    if (q.st == ST_FRAME && q.nbits >= DELIVER_LEN) begin
                        d.eop = 1'b1;
                        if (q.accept) begin
                            d.ov = 1'b1;
                            d.od = q.h2;
                            d.of = !q.emitted;
                            d.ol = 1'b1;
                            d.ok = (q.crc == CRC_GOOD) && (q.bcnt == '0)
                                   && (q.nbits >= GOOD_LEN);
                        end
                    end
                    d.st      = ST_FRAME;
                    d.dcnt    = '0;
                    d.bcnt    = '0;
                    d.nbits   = '0;
                    d.crc     = CRC_INIT;
                    d.hcnt    = '0;
                    d.emitted = 1'b0;
                    d.accept  = 1'b1;
                end else if (ev_abort) begin
                    if (q.st == ST_FRAME && q.nbits >= DELIVER_LEN) begin
                        d.eop = 1'b1;
                        d.ab  = (q.nbits >= GOOD_LEN);
                        if (q.accept) begin
                            d.ov = 1'b1;
                            d.od = q.h2;
                            d.of = !q.emitted;
                            d.ol = 1'b1;
                        end
                    end
                    d.st   = ST_HUNT;
                    d.dcnt = '0;
                end else if (ev_data && q.st == ST_FRAME) begin
                    d.dly = {q.dly[FLAG_LEN-3:0], bit_in};
                    if (q.dcnt != DLY_FULL) begin
                        d.dcnt = q.dcnt + 1'b1;
                    end else begin
                        // oldest delayed bit is now known not to be flag prefix
                        d.crc = crc_nxt;
                        if (q.nbits != '1) begin
                            d.nbits = q.nbits + 1'b1;
                        end
                        if (q.bcnt != BCNT_LAST) begin
                            d.sr   = {asm_bit, q.sr[PART_W-1:1]};
                            d.bcnt = q.bcnt + 1'b1;
                        end else begin
                            d.bcnt = '0;
                            if (q.nbits == FIRST_BYTE_END) begin
                                d.accept = !addr_filter_en || addr_hit;
                            end
                            if (q.hcnt == 2'd3) begin
                                if (q.accept) begin
                                    d.ov      = 1'b1;
                                    d.od      = q.h2;
                                    d.of      = !q.emitted;
                                    d.emitted = 1'b1;
                                end
                            end else begin
                                d.hcnt = q.hcnt + 1'b1;
                            end
                            d.h2 = q.h1;
                            d.h1 = q.h0;
                            d.h0 = asm_byte;
                        end
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q        <= '0;
            q.st     <= ST_HUNT;
            q.crc    <= CRC_INIT;
            q.accept <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign out_valid   = q.ov;
    assign out_data    = q.od;
    assign out_first   = q.of;
    assign out_last    = q.ol;
    assign out_fcs_ok  = q.ok;
    assign eop_pulse   = q.eop;
    assign abort_pulse = q.ab;
    assign idle_pulse  = q.idl;
    assign ga_pulse    = q.ga;
endmodule

// File: rtl/hdlc_rx_sva.sv
module hdlc_rx_sva (
    input logic clk,
    input logic rst_n,
    input logic bit_en,
    input logic transparent,
    input logic out_valid,
    input logic out_first,
    input logic out_last,
    input logic out_fcs_ok,
    input logic eop_pulse,
    input logic abort_pulse,
    input logic idle_pulse,
    input logic ga_pulse
);
    p_beat_after_strobe_r13: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(bit_en));

    p_pulse_after_strobe_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (eop_pulse || idle_pulse || ga_pulse || abort_pulse) |-> $past(bit_en));

    p_eop_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        eop_pulse |=> !eop_pulse);

    p_abort_with_eop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        abort_pulse |-> eop_pulse);

    p_ok_on_last_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_fcs_ok |-> (out_valid && out_last));

    p_markers_on_beat_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (out_first || out_last) |-> out_valid);

    p_raw_beat_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(transparent)) |-> (!out_first && !out_last && !out_fcs_ok));

    p_raw_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(transparent) && $past(bit_en)) |-> !(idle_pulse || ga_pulse || eop_pulse));
endmodule

bind hdlc_rx hdlc_rx_sva u_sva (.*);

// File: tb/hdlc_rx_test.sv
module hdlc_rx_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_en = 1'b0;
    logic bit_in = 1'b1;
    logic transparent = 1'b0;
    logic addr_filter_en = 1'b0;
    logic addr_six_bit = 1'b0;
    logic [7:0] station_addr = 8'h40;
    logic out_valid, out_first, out_last, out_fcs_ok;
    logic [7:0] out_data;
    logic eop_pulse, abort_pulse, idle_pulse, ga_pulse;

    int checks = 0;
    int errors = 0;
    int ones_run = 0;
    int cap_n = 0;
    int n_eop = 0, n_abort = 0, n_idle = 0, n_ga = 0;
    logic [7:0] cap_d [0:15];
    logic cap_f [0:15];
    logic cap_l [0:15];
    logic cap_ok [0:15];
    logic [7:0] fb [0:15];

    always #4 clk = ~clk;

    hdlc_rx uut (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_in(bit_in),
        .transparent(transparent), .addr_filter_en(addr_filter_en),
        .addr_six_bit(addr_six_bit), .station_addr(station_addr),
        .out_valid(out_valid), .out_data(out_data), .out_first(out_first),
        .out_last(out_last), .out_fcs_ok(out_fcs_ok), .eop_pulse(eop_pulse),
        .abort_pulse(abort_pulse), .idle_pulse(idle_pulse), .ga_pulse(ga_pulse)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (out_valid && cap_n < 16) begin
                cap_d[cap_n]  = out_data;
                cap_f[cap_n]  = out_first;
                cap_l[cap_n]  = out_last;
                cap_ok[cap_n] = out_fcs_ok;
                cap_n = cap_n + 1;
            end
            if (eop_pulse) n_eop = n_eop + 1;
            if (abort_pulse) n_abort = n_abort + 1;
            if (idle_pulse) n_idle = n_idle + 1;
            if (ga_pulse) n_ga = n_ga + 1;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic clear_cap();
        repeat (3) @(negedge clk);
        cap_n = 0; n_eop = 0; n_abort = 0; n_idle = 0; n_ga = 0;
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk);
        bit_in = b;
        bit_en = 1'b1;
        @(negedge clk);
        bit_en = 1'b0;
    endtask

    task automatic send_raw_byte(input logic [7:0] v);
        for (int i = 0; i < 8; i++) send_bit(v[i]);
    endtask

    task automatic send_flag();
        send_raw_byte(8'h7E);
        ones_run = 0;
    endtask

    task automatic send_ones(input int n);
        for (int i = 0; i < n; i++) send_bit(1'b1);
    endtask

    task automatic send_dbit(input logic b);
        send_bit(b);
        if (b) begin
            ones_run = ones_run + 1;
            if (ones_run == 5) begin
                send_bit(1'b0);
                ones_run = 0;
            end
        end else begin
            ones_run = 0;
        end
    endtask

    task automatic send_dbyte(input logic [7:0] v);
        for (int i = 0; i < 8; i++) send_dbit(v[i]);
    endtask

    function automatic logic [15:0] crc_add(input logic [15:0] c, input logic [7:0] v);
        logic [15:0] r = c;
        for (int i = 0; i < 8; i++) begin
            logic f = r[0] ^ v[i];
            r = r >> 1;
            if (f) r = r ^ 16'h8408;
        end
        return r;
    endfunction

    // mode 0 good FCS, 1 corrupted FCS, 2 no FCS, 3 good FCS plus three stray bits
    task automatic send_frame(input int n, input int mode);
        logic [15:0] c = 16'hFFFF;
        logic [15:0] fcs;
        send_flag();
        for (int i = 0; i < n; i++) begin
            c = crc_add(c, fb[i]);
            send_dbyte(fb[i]);
        end
        fcs = ~c;
        if (mode == 1) fcs = fcs ^ 16'h0001;
        if (mode != 2) begin
            send_dbyte(fcs[7:0]);
            send_dbyte(fcs[15:8]);
        end
        if (mode == 3) begin
            send_dbit(1'b1); send_dbit(1'b0); send_dbit(1'b1);
        end
        send_flag();
        send_flag();
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R13 reset out_valid", int'(out_valid), 0);
        chk("R13 reset pulses", int'(eop_pulse | abort_pulse | idle_pulse | ga_pulse), 0);
    endtask

    task automatic t_good();
        clear_cap();
        fb[0] = 8'h12; fb[1] = 8'hFF; fb[2] = 8'h7E; fb[3] = 8'h3F;
        send_frame(4, 0);
        chk("R3 good frame beat count", cap_n, 4);
        chk("R2 stuffed byte FF", int'(cap_d[1]), 'hFF);
        chk("R2 stuffed byte 7E", int'(cap_d[2]), 'h7E);
        chk("R1 first byte", int'(cap_d[0]), 'h12);
        chk("R1 first marker", int'(cap_f[0]), 1);
        chk("R1 no first marker on second", int'(cap_f[1]), 0);
        chk("R1 last marker", int'(cap_l[3]), 1);
        chk("R1 no early last", int'(cap_l[2]), 0);
        chk("R3 fcs ok", int'(cap_ok[3]), 1);
        chk("R9 R13 eop once", n_eop, 1);
    endtask

    task automatic t_badfcs();
        clear_cap();
        send_frame(4, 1);
        chk("R3 bad fcs beats", cap_n, 4);
        chk("R3 bad fcs flagged", int'(cap_ok[3]), 0);
        chk("R9 eop bad frame", n_eop, 1);
    endtask

    task automatic t_short();
        clear_cap();
        fb[0] = 8'hAA; fb[1] = 8'h55;
        send_frame(2, 2);
        chk("R4 short frame no beats", cap_n, 0);
        chk("R4 short frame no eop", n_eop, 0);
    endtask

    task automatic t_mid();
        clear_cap();
        fb[0] = 8'h81; fb[1] = 8'h42; fb[2] = 8'h24;
        send_frame(3, 2);
        chk("R5 24-bit frame beats", cap_n, 1);
        chk("R5 24-bit data", int'(cap_d[0]), 'h81);
        chk("R5 24-bit first+last", int'(cap_f[0] & cap_l[0]), 1);
        chk("R5 24-bit bad fcs", int'(cap_ok[0]), 0);
        chk("R9 24-bit eop", n_eop, 1);
    endtask

    task automatic t_odd();
        clear_cap();
        fb[0] = 8'h5A; fb[1] = 8'hC3;
        send_frame(2, 3);
        chk("R6 ragged frame beats", cap_n, 2);
        chk("R6 ragged last data", int'(cap_d[1]), 'hC3);
        chk("R6 ragged bad fcs", int'(cap_ok[1]), 0);
    endtask

    task automatic t_addr();
        addr_filter_en = 1'b1;
        station_addr = 8'h40;
        clear_cap();
        fb[0] = 8'h41; fb[1] = 8'h10;
        send_frame(2, 0);
        chk("R7 seven-bit match beats", cap_n, 2);
        chk("R7 match good fcs", int'(cap_ok[1]), 1);
        clear_cap();
        fb[0] = 8'h44;
        send_frame(2, 0);
        chk("R7 mismatch dropped", cap_n, 0);
        chk("R7 mismatch still eop", n_eop, 1);
        clear_cap();
        fb[0] = 8'hFF;
        send_frame(2, 0);
        chk("R7 broadcast accepted", cap_n, 2);
        addr_six_bit = 1'b1;
        clear_cap();
        fb[0] = 8'h43;
        send_frame(2, 0);
        chk("R7 six-bit match", cap_n, 2);
        clear_cap();
        fb[0] = 8'h48;
        send_frame(2, 0);
        chk("R7 six-bit mismatch", cap_n, 0);
        addr_six_bit = 1'b0;
        addr_filter_en = 1'b0;
        clear_cap();
        fb[0] = 8'h44;
        send_frame(2, 0);
        chk("R7 filter off accepts", cap_n, 2);
    endtask

    task automatic t_abort();
        clear_cap();
        send_flag();
        send_dbyte(8'h01); send_dbyte(8'h02); send_dbyte(8'h03);
        send_dbyte(8'h04); send_dbyte(8'h05);
        send_ones(8);
        repeat (3) @(negedge clk);
        chk("R8 long abort pulse", n_abort, 1);
        chk("R8 long abort eop", n_eop, 1);
        chk("R8 long abort beats", cap_n, 2);
        chk("R8 abort closing byte", int'(cap_d[1]), 'h02);
        chk("R8 abort closing last", int'(cap_l[1]), 1);
        chk("R8 abort closing bad", int'(cap_ok[1]), 0);
        clear_cap();
        send_flag();
        send_dbyte(8'h11); send_dbyte(8'h22);
        send_ones(8);
        repeat (3) @(negedge clk);
        chk("R8 short abort no pulse", n_abort, 0);
        chk("R8 short abort no eop", n_eop, 0);
        chk("R8 short abort no beats", cap_n, 0);
        clear_cap();
        fb[0] = 8'h66; fb[1] = 8'h99;
        send_frame(2, 0);
        chk("R8 resync after abort", int'(cap_ok[1]), 1);
    endtask

    task automatic t_idle();
        clear_cap();
        send_ones(16);
        send_flag();
        repeat (3) @(negedge clk);
        chk("R10 idle once", n_idle, 1);
        chk("R11 no go-ahead on long run", n_ga, 0);
        chk("R10 idle no eop", n_eop, 0);
    endtask

    task automatic t_ga();
        clear_cap();
        send_flag();
        send_ones(7);
        send_bit(1'b0);
        repeat (3) @(negedge clk);
        chk("R11 go-ahead seen", n_ga, 1);
        clear_cap();
        send_bit(1'b0);
        send_ones(8);
        send_bit(1'b0);
        repeat (3) @(negedge clk);
        chk("R11 eight ones no go-ahead", n_ga, 0);
        send_flag();
    endtask

    task automatic t_trans();
        clear_cap();
        @(negedge clk);
        transparent = 1'b1;
        send_raw_byte(8'hA5); send_raw_byte(8'hFF);
        send_raw_byte(8'hFF); send_raw_byte(8'h7E);
        repeat (3) @(negedge clk);
        chk("R12 raw beat count", cap_n, 4);
        chk("R12 raw byte0", int'(cap_d[0]), 'hA5);
        chk("R12 raw byte3", int'(cap_d[3]), 'h7E);
        chk("R12 raw markers", int'(cap_f[0] | cap_l[3] | cap_ok[3]), 0);
        chk("R12 no idle in raw", n_idle, 0);
        chk("R12 no eop in raw", n_eop, 0);
        transparent = 1'b0;
        send_flag();
        send_flag();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors = errors + 1;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        send_flag();
        send_flag();
        t_good();
        t_badfcs();
        t_short();
        t_mid();
        t_odd();
        t_addr();
        t_abort();
        t_idle();
        t_ga();
        t_trans();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule